// File: doc/BRIEF.md
# Total-Store-Order Store Buffer

This block sits between one core's memory-request port and its private cache. Stores are posted: they are placed in a small in-order queue and written to the cache later through the write channel, oldest first. Loads do not wait for that queue to drain. A load whose address matches a queued store is answered from the youngest matching entry. A load that matches no entry goes straight to the cache read channel. The only ordering this relaxes is a store followed by a load. Store-to-store, load-to-load and load-to-store order are all kept.

Fences and atomic swaps are the ordering points. A fence holds the core until every queued store has been accepted by the cache. A swap first waits for the queue to empty. It then reads the old value and writes the new one, with no other request accepted between the read and the write, and returns the old value. The core request port is valid/ready. `req_ready` may depend on the operation: a store is refused only while the queue is full, and nothing is accepted while a load, fence or swap is in progress. The response port is a one-cycle `rsp_valid` pulse with no back-pressure. Both cache request channels are valid/ready, and an offered request stays unchanged until it is accepted. Cache read responses come back in order as a one-cycle pulse.

Top module: `tso_store_buffer`

## Requirements
- R1: Operation codes are 0 load, 1 store, 2 fence, 3 swap. A load to an address with no queued store is sent as one cache read, even while older stores to other addresses are still queued. Its response carries the cache data.
- R2: A load whose address matches queued stores returns the data of the youngest match. The response comes in the cycle after acceptance, and no cache read is issued.
- R3: Queued stores leave through the write channel in program order. While `cwr_valid` is high and `cwr_ready` is low, the address and data stay stable.
- R4: The queue holds 8 stores. While it is full, a store sees `req_ready` low, but a load is still accepted.
- R5: At most one cache read is outstanding. Reads are issued in program order, and a read request stays stable until it is accepted.
- R6: An entry leaves the queue only on a write-channel handshake, so every store reaches the cache exactly once.
- R7: A fence responds, with data 0, exactly in the cycle after the queue is first seen empty. It never responds while stores remain queued.
- R8: A swap waits for the queue to empty, reads the old value, writes the new value through the write channel and returns the old value. No request is accepted and no queued store is written between its read and its write.
- R9: After reset the queue is empty, `cwr_valid`, `crd_req_valid` and `rsp_valid` are low, and `req_ready` is high for a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Core request accepted this cycle when high with valid |
| req_op | input | 2 | Operation code (R1) |
| req_addr | input | ADDR_W | Request address |
| req_data | input | DATA_W | Store or swap data |
| rsp_valid | output | 1 | One-cycle response pulse for load, fence, swap |
| rsp_data | output | DATA_W | Load data, swap old value, 0 for fence |
| cwr_valid | output | 1 | Cache write request valid |
| cwr_ready | input | 1 | Cache write request accepted |
| cwr_addr | output | ADDR_W | Cache write address |
| cwr_data | output | DATA_W | Cache write data |
| crd_req_valid | output | 1 | Cache read request valid |
| crd_req_ready | input | 1 | Cache read request accepted |
| crd_req_addr | output | ADDR_W | Cache read address |
| crd_rsp_valid | input | 1 | Cache read data pulse |
| crd_rsp_data | input | DATA_W | Cache read data |

## Verification
Two things can fall in the same cycle: the queue draining its head entry to the cache, and the core pushing a new store or forwarding a load from the queue. The random phase keeps the cache write ready random while stores and loads are issued back to back to a few addresses, so pops, pushes and lookups overlap. Every value is judged against a bench model in which a load sees the youngest pending store, or else the cache copy, and every write handshake is matched against the model's oldest pending store. A directed case holds the write channel stalled with several stores to one address, then checks the forwarded value, the one-cycle timing, and fence and full-queue behaviour.

// File: rtl/tsb_pkg.sv
package tsb_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_FENCE = 2'd2,
    OP_SWAP  = 2'd3
  } tsb_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LD_REQ,
    ST_LD_WAIT,
    ST_FENCE,
    ST_SW_DRAIN,
    ST_SW_REQ,
    ST_SW_WAIT,
    ST_SW_WR
  } tsb_state_e;
endpackage

// File: rtl/tsb_queue.sv
// In-order store queue with an associative lookup that picks the youngest match.
// DEPTH must be a power of two.
module tsb_queue #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [ADDR_W-1:0] head_addr,
  output logic [DATA_W-1:0] head_data,
  output logic              full,
  output logic              empty,
  input  logic [ADDR_W-1:0] look_addr,
  output logic              look_hit,
  output logic [DATA_W-1:0] look_data
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = PTR_W + 1;

  logic [ADDR_W-1:0] addr_mem [DEPTH];
  logic [DATA_W-1:0] data_mem [DEPTH];
  logic [PTR_W-1:0]  head_q, tail_q;
  logic [CNT_W-1:0]  count_q;
  logic [DEPTH-1:0]  addr_eq;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign addr_eq[i] = (addr_mem[i] == look_addr);
  end

  always_ff @(posedge clk) begin
    if (push) begin
      addr_mem[tail_q] <= push_addr;
      data_mem[tail_q] <= push_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (push) tail_q <= tail_q + 1'b1;
      if (pop)  head_q <= head_q + 1'b1;
      case ({push, pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign full      = (count_q == CNT_W'(DEPTH));
  assign empty     = (count_q == '0);
  assign head_addr = addr_mem[head_q];
  assign head_data = data_mem[head_q];

  // Walk from oldest to youngest; a later match overrides an earlier one.
  always_comb begin
    logic [PTR_W-1:0] idx;
    look_hit  = 1'b0;
    look_data = '0;
    idx       = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head_q + PTR_W'(k);
      if ((CNT_W'(k) < count_q) && addr_eq[idx]) begin
        look_hit  = 1'b1;
        look_data = data_mem[idx];
      end
    end
  end
endmodule

// File: rtl/tsb_ctrl.sv
// Request sequencing: forwarding, blocking loads, fences and swaps.
module tsb_ctrl
  import tsb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              req_ready,
  input  logic              buf_full,
  input  logic              buf_empty,
  input  logic              fwd_hit,
  input  logic [DATA_W-1:0] fwd_data,
  output logic              push,
  output logic              crd_req_valid,
  output logic [ADDR_W-1:0] crd_req_addr,
  input  logic              crd_req_ready,
  input  logic              crd_rsp_valid,
  input  logic [DATA_W-1:0] crd_rsp_data,
  output logic              sw_wr_valid,
  output logic [ADDR_W-1:0] sw_addr,
  output logic [DATA_W-1:0] sw_data,
  input  logic              sw_wr_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              busy,
  output logic              fence_wait
);
  tsb_state_e        state_q;
  tsb_op_e           op;
  logic              accept;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_q;

  assign op            = tsb_op_e'(req_op);
  assign req_ready     = (state_q == ST_IDLE) && !((op == OP_STORE) && buf_full);
  assign accept        = req_valid && req_ready;
  assign push          = accept && (op == OP_STORE);
  assign crd_req_valid = (state_q == ST_LD_REQ) || (state_q == ST_SW_REQ);
  assign crd_req_addr  = addr_q;
  assign sw_wr_valid   = (state_q == ST_SW_WR);
  assign sw_addr       = addr_q;
  assign sw_data       = data_q;
  assign rsp_valid     = rsp_valid_q;
  assign rsp_data      = rsp_data_q;
  assign busy          = (state_q != ST_IDLE);
  assign fence_wait    = (state_q == ST_FENCE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      data_q      <= '0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (accept) begin
          case (op)
            OP_LOAD: if (fwd_hit) begin
              rsp_valid_q <= 1'b1;
              rsp_data_q  <= fwd_data;
            end else begin
              addr_q  <= req_addr;
              state_q <= ST_LD_REQ;
            end
            OP_FENCE: state_q <= ST_FENCE;
            OP_SWAP: begin
              addr_q  <= req_addr;
              data_q  <= req_data;
              state_q <= ST_SW_DRAIN;
            end
            default: ;
          endcase
        end
        ST_LD_REQ:  if (crd_req_ready) state_q <= ST_LD_WAIT;
        ST_LD_WAIT: if (crd_rsp_valid) begin
          rsp_valid_q <= 1'b1;
          rsp_data_q  <= crd_rsp_data;
          state_q     <= ST_IDLE;
        end
        ST_FENCE: if (buf_empty) begin
          rsp_valid_q <= 1'b1;
          rsp_data_q  <= '0;
          state_q     <= ST_IDLE;
        end
        ST_SW_DRAIN: if (buf_empty) state_q <= ST_SW_REQ;
        ST_SW_REQ:   if (crd_req_ready) state_q <= ST_SW_WAIT;
        ST_SW_WAIT: if (crd_rsp_valid) begin
          rsp_data_q <= crd_rsp_data;
          state_q    <= ST_SW_WR;
        end
        ST_SW_WR: if (sw_wr_ready) begin
          rsp_valid_q <= 1'b1;
          state_q     <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tso_store_buffer.sv
module tso_store_buffer #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              cwr_valid,
  input  logic              cwr_ready,
  output logic [ADDR_W-1:0] cwr_addr,
  output logic [DATA_W-1:0] cwr_data,
  output logic              crd_req_valid,
  input  logic              crd_req_ready,
  output logic [ADDR_W-1:0] crd_req_addr,
  input  logic              crd_rsp_valid,
  input  logic [DATA_W-1:0] crd_rsp_data
);
  logic              buf_full, buf_empty, buf_push, buf_pop;
  logic              fwd_hit;
  logic [DATA_W-1:0] fwd_data;
  logic [ADDR_W-1:0] head_addr, sw_addr;
  logic [DATA_W-1:0] head_data, sw_data;
  logic              sw_wr_valid, ctl_busy, ctl_fence;

  tsb_queue #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .push(buf_push), .push_addr(req_addr), .push_data(req_data),
    .pop(buf_pop), .head_addr(head_addr), .head_data(head_data),
    .full(buf_full), .empty(buf_empty),
    .look_addr(req_addr), .look_hit(fwd_hit), .look_data(fwd_data)
  );

  tsb_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_data(req_data), .req_ready(req_ready),
    .buf_full(buf_full), .buf_empty(buf_empty),
    .fwd_hit(fwd_hit), .fwd_data(fwd_data), .push(buf_push),
    .crd_req_valid(crd_req_valid), .crd_req_addr(crd_req_addr),
    .crd_req_ready(crd_req_ready), .crd_rsp_valid(crd_rsp_valid),
    .crd_rsp_data(crd_rsp_data),
    .sw_wr_valid(sw_wr_valid), .sw_addr(sw_addr), .sw_data(sw_data),
    .sw_wr_ready(cwr_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .busy(ctl_busy), .fence_wait(ctl_fence)
  );

  // The swap write only happens with the queue empty, so sharing the channel keeps order.
  assign cwr_valid = sw_wr_valid || !buf_empty;
  assign cwr_addr  = sw_wr_valid ? sw_addr : head_addr;
  assign cwr_data  = sw_wr_valid ? sw_data : head_data;
  assign buf_pop   = !sw_wr_valid && !buf_empty && cwr_ready;
endmodule

// File: rtl/tsb_checker.sv
module tsb_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic [1:0]        req_op,
  input logic              rsp_valid,
  input logic              cwr_valid,
  input logic              cwr_ready,
  input logic [ADDR_W-1:0] cwr_addr,
  input logic [DATA_W-1:0] cwr_data,
  input logic              crd_req_valid,
  input logic              crd_req_ready,
  input logic [ADDR_W-1:0] crd_req_addr,
  input logic              full,
  input logic              empty,
  input logic              busy,
  input logic              fence_wait
);
  // R4
  full_store_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && req_op == 2'd1) |-> !req_ready);
  // R3
  cwr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cwr_valid && !cwr_ready) |=> (cwr_valid && $stable(cwr_addr) && $stable(cwr_data)));
  // R5
  crd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (crd_req_valid && !crd_req_ready) |=> (crd_req_valid && $stable(crd_req_addr)));
  // R5
  one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (crd_req_valid && crd_req_ready) |=> !crd_req_valid);
  // R8
  busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);
  // R7
  fence_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fence_wait && !empty) |=> !rsp_valid);
  // R7
  fence_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fence_wait && empty) |=> rsp_valid);
endmodule

bind tso_store_buffer tsb_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .req_op(req_op),
  .rsp_valid(rsp_valid), .cwr_valid(cwr_valid), .cwr_ready(cwr_ready),
  .cwr_addr(cwr_addr), .cwr_data(cwr_data), .crd_req_valid(crd_req_valid),
  .crd_req_ready(crd_req_ready), .crd_req_addr(crd_req_addr),
  .full(buf_full), .empty(buf_empty), .busy(ctl_busy), .fence_wait(ctl_fence)
);

// File: tb/tb_tso_store_buffer.sv
module tb_tso_store_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'd0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_data = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        cwr_valid, cwr_ready = 1'b0;
  logic [15:0] cwr_addr;
  logic [31:0] cwr_data;
  logic        crd_req_valid, crd_req_ready = 1'b0;
  logic [15:0] crd_req_addr;
  logic        crd_rsp_valid = 1'b0;
  logic [31:0] crd_rsp_data = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tso_store_buffer dut (.*);

  int checks = 0, fails = 0;
  bit done = 1'b0, block_wr = 1'b0, sw_pend = 1'b0;
  logic [31:0] mem [16];
  logic [15:0] q_addr [$];
  logic [31:0] q_data [$];
  logic [31:0] exp_data [$];
  int          exp_kind [$];
  logic [15:0] sw_a;
  logic [31:0] sw_d, rd_addr;
  int          rd_lat = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lookup(input logic [15:0] a);
    logic [31:0] v = mem[a[3:0]];
    foreach (q_addr[i]) if (q_addr[i] == a) v = q_data[i];
    return v;
  endfunction

  // Cache and response model, evaluated at the falling edge.
  always @(negedge clk) if (rst_n) begin
    if (rsp_valid) begin
      if (exp_data.size() == 0) chk(0, "R1 unexpected rsp", rsp_data, 0);
      else begin
        chk(rsp_data == exp_data[0],
            exp_kind[0] == 2 ? "R7 fence rsp" : exp_kind[0] == 3 ? "R8 swap old value" : "R1/R2 load data",
            rsp_data, exp_data[0]);
        if (exp_kind[0] == 2) chk(q_addr.size() == 0, "R7 fence before drain", q_addr.size(), 0);
        void'(exp_data.pop_front());
        void'(exp_kind.pop_front());
      end
    end
    crd_rsp_valid = 1'b0;
    if (rd_lat > 0) begin
      rd_lat--;
      if (rd_lat == 0) begin
        crd_rsp_valid = 1'b1;
        crd_rsp_data  = mem[rd_addr[3:0]];
      end
    end
    cwr_ready     = block_wr ? 1'b0 : ($urandom_range(0, 9) < 7);
    crd_req_ready = ($urandom_range(0, 9) < 7);
    if (crd_req_valid && crd_req_ready) begin
      chk(rd_lat == 0, "R5 second read outstanding", rd_lat, 0);
      rd_addr = {16'd0, crd_req_addr};
      rd_lat  = $urandom_range(1, 3);
    end
    if (cwr_valid && cwr_ready) begin
      if (q_addr.size() > 0) begin
        chk(cwr_addr == q_addr[0] && cwr_data == q_data[0], "R3/R6 write order",
            {cwr_addr, cwr_data[15:0]}, {q_addr[0], q_data[0][15:0]});
        void'(q_addr.pop_front());
        void'(q_data.pop_front());
      end else begin
        chk(sw_pend && cwr_addr == sw_a && cwr_data == sw_d, "R8 swap write",
            cwr_data, sw_d);
        sw_pend = 1'b0;
      end
      mem[cwr_addr[3:0]] = cwr_data;
    end
  end

  task automatic issue(input logic [1:0] op, input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
    #1;
    while (!req_ready) begin @(negedge clk); #2; end
    case (op)
      2'd0: begin exp_data.push_back(lookup(a)); exp_kind.push_back(0); end
      2'd1: begin q_addr.push_back(a); q_data.push_back(d); end
      2'd2: begin exp_data.push_back(0); exp_kind.push_back(2); end
      default: begin
        exp_data.push_back(lookup(a)); exp_kind.push_back(3);
        sw_pend = 1'b1; sw_a = a; sw_d = d;
      end
    endcase
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      chk(0, "R5 watchdog progress", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < 16; i++) mem[i] = 32'h100 * i + 7;
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    chk(req_ready && !cwr_valid && !crd_req_valid && !rsp_valid, "R9 reset outputs",
        {req_ready, cwr_valid, crd_req_valid, rsp_valid}, 4'b1000);
    rst_n = 1'b1;

    // Directed: stalled write channel, forwarding, full queue, fence.
    block_wr = 1'b1;
    issue(2'd1, 16'd0, 32'h10);
    issue(2'd1, 16'd1, 32'h20);
    issue(2'd1, 16'd0, 32'h30);
    @(negedge clk); #1;
    // R3 head held while stalled
    chk(cwr_valid && cwr_addr == 16'd0 && cwr_data == 32'h10, "R3 stalled head", cwr_data, 32'h10);
    issue(2'd0, 16'd0, 0);
    @(negedge clk); #1;
    // R2 youngest match, next cycle, no read
    chk(rsp_valid && rsp_data == 32'h30, "R2 forward youngest", rsp_data, 32'h30);
    chk(!crd_req_valid, "R2 no cache read", crd_req_valid, 0);
    issue(2'd0, 16'd5, 0);  // R1 bypass to cache while stores queued
    for (int i = 0; i < 5; i++) issue(2'd1, 16'(8 + i), 32'h40 + i);
    @(negedge clk); #1;
    req_valid = 1'b1; req_op = 2'd1; req_addr = 16'd9; req_data = 32'h99;
    #1;
    chk(!req_ready, "R4 store blocked when full", req_ready, 0);
    req_op = 2'd0; req_addr = 16'd1;
    #1;
    chk(req_ready, "R4 load accepted when full", req_ready, 1);
    req_valid = 1'b0;
    issue(2'd0, 16'd1, 0);
    issue(2'd2, 0, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1;
      chk(!rsp_valid, "R7 fence held while queued", rsp_valid, 0);
    end
    block_wr = 1'b0;
    issue(2'd3, 16'd0, 32'hABC);  // R8 swap after fence
    issue(2'd0, 16'd0, 0);

    // Random mix.
    for (int n = 0; n < 600; n++) begin
      int r = $urandom_range(0, 99);
      logic [15:0] a = 16'($urandom_range(0, 5));
      logic [31:0] d = $urandom;
      if (r < 35) issue(2'd0, a, 0);
      else if (r < 82) issue(2'd1, a, d);
      else if (r < 90) issue(2'd2, 0, 0);
      else issue(2'd3, a, d);
    end
    issue(2'd2, 0, 0);
    for (int i = 0; i < 200 && exp_data.size() > 0; i++) @(negedge clk);
    #2;
    chk(exp_data.size() == 0 && q_addr.size() == 0, "R6 all drained",
        exp_data.size() + q_addr.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule